// File: doc/BRIEF.md
# Partial Configuration Stream Version Gate

This block sits between the source of a partial configuration stream and the port that loads it into configuration memory. Each stream opens with one header word that carries the version tag of the static design it was built for. The gate compares that tag with the identifier of the static design now running, which arrives as a constant input. Only on a match does it pass the payload words that follow on to the configuration port. On a mismatch it consumes and discards the rest of the stream and raises an error flag, so no word of an incompatible image ever reaches the port.

Both sides use a valid/ready handshake with an end-of-stream marker. While payload is passing, the gate is a combinational pass-through, so the downstream port throttles the source directly and adds no latency. Whenever the gate is not forwarding, its output data bus is held at zero. The error flag stays set until software clears it. A one-cycle match pulse reports each stream that passes the check. The choice of fallback action is left to the surrounding system.

Top module: `pbit_version_gate`

## Requirements
- R1: After reset, `dn_valid` is 0, `err_o` is 0, `match_o` is 0, and `up_ready` is 1, because the gate is waiting for a header.
- R2: The first accepted beat of every stream is the header and never appears on the output. The payload beats that follow a matching header leave on `dn_data` in their original order with their values unchanged.
- R3: `dn_last` is 1 on the final payload beat of a forwarded stream and 0 on every other forwarded beat.
- R4: While payload is forwarded, `dn_valid` follows `up_valid`, and `up_ready` follows `dn_ready`. A downstream stall therefore stalls the source.
- R5: A header whose bits [VER_W-1:0] equal `static_id`, and whose `up_last` is 0, makes `match_o` high for exactly the one cycle after that header is accepted.
- R6: After a mismatching header, `up_ready` stays 1 and `dn_valid` stays 0 until the beat with `up_last` = 1 has been accepted. The next beat after that is treated as a new header.
- R7: A mismatching header sets `err_o` in the cycle after it is accepted. `err_o` then stays 1 until a clear pulse arrives.
- R8: A one-cycle pulse on `err_clr` clears `err_o` at the next edge. If a new error arises in the same cycle, the error wins and `err_o` stays 1.
- R9: A header beat that has `up_last` = 1 is malformed. It sets `err_o`, gives no match pulse and forwards nothing, and the next beat is taken as a new header.
- R10: No beat is presented on the output while the gate is waiting for a header. The version check therefore always completes before any configuration word can reach the port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| static_id | input | VER_W | Version identifier of the running static design |
| up_valid | input | 1 | Incoming stream beat valid |
| up_ready | output | 1 | Gate accepts the incoming beat |
| up_data | input | DATA_W | Incoming stream word |
| up_last | input | 1 | Incoming beat ends the stream |
| dn_valid | output | 1 | Beat toward the configuration port valid |
| dn_ready | input | 1 | Configuration port accepts the beat |
| dn_data | output | DATA_W | Word toward the configuration port |
| dn_last | output | 1 | Final payload beat of the stream |
| err_clr | input | 1 | One-cycle clear pulse for the error flag |
| err_o | output | 1 | Sticky error flag: version mismatch or malformed header |
| match_o | output | 1 | One-cycle pulse for each accepted header that matches |

## Verification
On every cycle, the assertions check the port-level rules. They confirm that nothing leaves the gate while it waits for a header or drains a rejected stream. They confirm that backpressure and the forwarded data are coupled. They also track the effect of each header verdict on the flags in the following cycle, and the hold and clear behaviour of the error flag. Some properties are visible only across whole streams, and only the bench scenarios can show them. These are the ordered, unchanged delivery of every payload word under random stalls on both sides, and a drain that never stalls the source. They also include recovery to a clean header after a rejected or malformed stream, and the precedence of a new error over a clear arriving in the same cycle.

// File: rtl/pvg_pkg.sv
`timescale 1ns/1ps
package pvg_pkg;

  // Gate phases: waiting for the version header, passing payload, discarding a rejected stream
  typedef enum logic [1:0] {
    PH_HEAD = 2'd0,
    PH_PASS = 2'd1,
    PH_DROP = 2'd2
  } pvg_phase_e;

  // Verdict on one header beat
  typedef struct packed {
    logic take;   // header beat accepted this cycle
    logic good;   // tag matched and stream continues
    logic bad;    // tag did not match
    logic short;  // header carried the end marker
  } pvg_verdict_t;

endpackage

// File: rtl/pvg_tag_cmp.sv
`timescale 1ns/1ps
module pvg_tag_cmp #(
  parameter int DATA_W  = 32,
  parameter int VER_W   = 32,
  parameter int VER_LSB = 0
) (
  input  logic [DATA_W-1:0] word_i,
  input  logic [VER_W-1:0]  ref_i,
  output logic              equal_o
);

  localparam int VER_MSB = VER_LSB + VER_W - 1;

  generate
    if (VER_W == DATA_W) begin : g_full
      // tag occupies the whole header word
      assign equal_o = (word_i == ref_i);
    end else begin : g_slice
      logic [VER_W-1:0] tag;
      assign tag     = word_i[VER_MSB:VER_LSB];
      assign equal_o = (tag == ref_i);
    end
  endgenerate

endmodule

// File: rtl/pvg_ctrl.sv
`timescale 1ns/1ps
module pvg_ctrl
  import pvg_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  input  logic         up_last,
  input  logic         dn_ready,
  input  logic         tag_eq,
  output pvg_phase_e   phase_o,
  output pvg_verdict_t verdict_o
);

  pvg_phase_e   phase_q, phase_d;
  pvg_verdict_t vd;
  logic         phase_en;

  // next-state process
  always_comb begin
    phase_d = phase_q;
    vd      = '0;
    unique case (phase_q)
      PH_HEAD: begin
        if (up_valid) begin
          vd.take = 1'b1;
          if (up_last) begin
            vd.short = 1'b1;          // malformed: stay waiting for a header
          end else if (tag_eq) begin
            vd.good = 1'b1;
            phase_d = PH_PASS;
          end else begin
            vd.bad  = 1'b1;
            phase_d = PH_DROP;
          end
        end
      end
      PH_PASS: begin
        if (up_valid && dn_ready && up_last) phase_d = PH_HEAD;
      end
      PH_DROP: begin
        if (up_valid && up_last) phase_d = PH_HEAD;
      end
      default: phase_d = PH_HEAD;
    endcase
  end

  assign phase_en = (phase_d != phase_q);

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_HEAD;
    end else if (phase_en) begin
      phase_q <= phase_d;
    end
  end

  assign phase_o   = phase_q;
  assign verdict_o = vd;

endmodule

// File: rtl/pvg_flags.sv
`timescale 1ns/1ps
module pvg_flags
  import pvg_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  pvg_verdict_t verdict_i,
  input  logic         clr_i,
  output logic         err_o,
  output logic         match_o
);

  logic err_q, err_d, err_en;
  logic hit_q, hit_d, hit_en;
  logic raise;

  // next-state process
  always_comb begin
    raise  = verdict_i.bad | verdict_i.short;
    err_d  = raise | (err_q & ~clr_i);   // a new error outranks a clear
    err_en = raise | clr_i;
    hit_d  = verdict_i.good;
    hit_en = hit_q | verdict_i.good;
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
      hit_q <= 1'b0;
    end else begin
      if (err_en) err_q <= err_d;
      if (hit_en) hit_q <= hit_d;
    end
  end

  assign err_o   = err_q;
  assign match_o = hit_q;

endmodule

// File: rtl/pbit_version_gate.sv
`timescale 1ns/1ps
module pbit_version_gate
  import pvg_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int VER_W   = 32,
  parameter int VER_LSB = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VER_W-1:0]  static_id,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [DATA_W-1:0] up_data,
  input  logic              up_last,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [DATA_W-1:0] dn_data,
  output logic              dn_last,
  input  logic              err_clr,
  output logic              err_o,
  output logic              match_o
);

  pvg_phase_e   phase;
  pvg_verdict_t verdict;
  logic         tag_eq;
  logic         passing;

  pvg_tag_cmp #(
    .DATA_W (DATA_W),
    .VER_W  (VER_W),
    .VER_LSB(VER_LSB)
  ) u_cmp (
    .word_i (up_data),
    .ref_i  (static_id),
    .equal_o(tag_eq)
  );

  pvg_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (up_valid),
    .up_last  (up_last),
    .dn_ready (dn_ready),
    .tag_eq   (tag_eq),
    .phase_o  (phase),
    .verdict_o(verdict)
  );

  pvg_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .verdict_i(verdict),
    .clr_i    (err_clr),
    .err_o    (err_o),
    .match_o  (match_o)
  );

  // datapath: pass-through only in the payload phase, isolated otherwise
  always_comb begin
    passing  = (phase == PH_PASS);
    dn_valid = passing & up_valid;
    dn_data  = passing ? up_data : '0;
    dn_last  = passing & up_last;
    up_ready = passing ? dn_ready : 1'b1;
  end

endmodule

// File: rtl/pvg_checker.sv
`timescale 1ns/1ps
module pvg_checker #(
  parameter int DATA_W  = 32,
  parameter int VER_W   = 32,
  parameter int VER_LSB = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [VER_W-1:0]  static_id,
  input logic              up_valid,
  input logic              up_ready,
  input logic [DATA_W-1:0] up_data,
  input logic              up_last,
  input logic              dn_valid,
  input logic              dn_ready,
  input logic [DATA_W-1:0] dn_data,
  input logic              dn_last,
  input logic              err_clr,
  input logic              err_o,
  input logic              match_o
);

  // framing shadow built from the input handshake only
  logic acc, head_exp, dropping, tag_hit;
  assign acc     = up_valid & up_ready;
  assign tag_hit = (up_data[VER_LSB +: VER_W] == static_id);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_exp <= 1'b1;
      dropping <= 1'b0;
    end else begin
      if (acc) head_exp <= up_last;
      if (acc && head_exp && !up_last && !tag_hit) dropping <= 1'b1;
      else if (acc && dropping && up_last)         dropping <= 1'b0;
    end
  end

  // R10
  no_out_on_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    head_exp |-> (!dn_valid && up_ready));

  // R6
  drain_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dropping |-> (!dn_valid && up_ready));

  // R4
  backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> (up_valid && (up_ready == dn_ready)));

  // R2
  data_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> (dn_data == up_data && dn_last == up_last));

  // R5
  match_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && head_exp && !up_last && tag_hit) |=> match_o);

  // R5
  match_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |=> !match_o);

  // R7
  err_on_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && head_exp && !up_last && !tag_hit) |=> (err_o && !match_o));

  // R9
  err_on_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && head_exp && up_last) |=> (err_o && !match_o));

  // R7
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !err_clr) |=> err_o);

  // R8
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !up_valid) |=> !err_o);

endmodule

bind pbit_version_gate pvg_checker #(
  .DATA_W (DATA_W),
  .VER_W  (VER_W),
  .VER_LSB(VER_LSB)
) u_pvg_chk (.*);

// File: tb/pbit_version_gate_bench.sv
`timescale 1ns/1ps
module pbit_version_gate_bench;

  localparam int DW = 32;
  localparam logic [31:0] ID_A = 32'hA5C3_0017;
  localparam logic [31:0] ID_B = 32'h0B1E_77D2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [31:0]   static_id;
  logic          up_valid, up_ready, up_last;
  logic [DW-1:0] up_data;
  logic          dn_valid, dn_ready, dn_last;
  logic [DW-1:0] dn_data;
  logic          err_clr, err_o, match_o;

  always #4 clk = ~clk;   // 125 MHz

  pbit_version_gate u_pbit_version_gate (
    .clk(clk), .rst_n(rst_n), .static_id(static_id),
    .up_valid(up_valid), .up_ready(up_ready), .up_data(up_data), .up_last(up_last),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_data(dn_data), .dn_last(dn_last),
    .err_clr(err_clr), .err_o(err_o), .match_o(match_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int stalls;
  int match_cnt = 0;
  bit bp_en = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic [32:0] exp_q[$];

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // downstream readiness pattern
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    dn_ready = bp_en ? lfsr[0] : 1'b1;
  end

  always @(negedge clk) if (match_o) match_cnt++;

  // monitor: compare each output handshake against the scoreboard
  initial begin
    logic [32:0] e;
    forever begin
      @(negedge clk);
      #3;
      if (dn_valid && !dn_ready)
        check(up_ready == 1'b0, "R4 stall", up_ready, 0);
      if (dn_valid && dn_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6/R10 unexpected output beat", dn_data, 0);
        end else begin
          e = exp_q.pop_front();
          check(dn_data == e[31:0], "R2 data", dn_data, e[31:0]);
          check(dn_last == e[32], "R3 last", dn_last, e[32]);
        end
      end
    end
  end

  // driver: header plus n payload beats; pushes the beats expected at the output
  task automatic send(input logic [31:0] hdr, input int n, input logic [31:0] seed,
                      input bit gaps, input bit fwd);
    stalls = 0;
    for (int i = 0; i <= n; i++) begin
      @(negedge clk);
      if (gaps && (i % 3 == 2)) begin
        up_valid = 1'b0;
        @(negedge clk);
      end
      up_valid = 1'b1;
      up_last  = (i == n);
      up_data  = (i == 0) ? hdr : seed + i * 32'h0101_0101;
      if (fwd && i > 0) exp_q.push_back({up_last, up_data});
      forever begin
        #3;
        if (up_ready) break;
        stalls++;
        @(negedge clk);
      end
    end
    @(negedge clk);
    up_valid = 1'b0;
    up_last  = 1'b0;
  endtask

  task automatic idle(input int c);
    repeat (c) @(negedge clk);
    #3;
  endtask

  initial begin
    int m0;
    rst_n = 1'b0; static_id = ID_A; up_valid = 1'b0; up_last = 1'b0;
    up_data = '0; err_clr = 1'b0; dn_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #3;
    // R1 reset state
    check(dn_valid == 0, "R1 dn_valid", dn_valid, 0);
    check(err_o == 0, "R1 err_o", err_o, 0);
    check(match_o == 0, "R1 match_o", match_o, 0);
    check(up_ready == 1, "R1 up_ready", up_ready, 1);

    // R2 R3 R5 matching stream, no stalls
    m0 = match_cnt;
    send(ID_A, 4, 32'h1000_0000, 1'b0, 1'b1);
    idle(3);
    check(match_cnt - m0 == 1, "R5 one match pulse", match_cnt - m0, 1);
    check(exp_q.size() == 0, "R2 all payload delivered", exp_q.size(), 0);
    check(err_o == 0, "R7 no error on match", err_o, 0);

    // R4 backpressure and source gaps
    bp_en = 1'b1;
    send(ID_A, 9, 32'h2222_0000, 1'b1, 1'b1);
    idle(4);
    check(exp_q.size() == 0, "R4 payload under stalls", exp_q.size(), 0);

    // R6 R7 mismatched stream drained without stalls or output
    m0 = match_cnt;
    send(ID_B, 6, 32'h3300_0000, 1'b0, 1'b0);
    check(stalls == 0, "R6 drain never stalls", stalls, 0);
    idle(3);
    check(err_o == 1, "R7 error set", err_o, 1);
    check(match_cnt == m0, "R7 no match on mismatch", match_cnt - m0, 0);
    idle(10);
    check(err_o == 1, "R7 error sticky", err_o, 1);

    // R6 next stream after drain is a fresh header
    send(ID_A, 2, 32'h4400_0000, 1'b1, 1'b1);
    idle(4);
    check(exp_q.size() == 0, "R6 recovery after drain", exp_q.size(), 0);
    check(err_o == 1, "R7 error still held", err_o, 1);

    // R8 clear
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    #3;
    check(err_o == 0, "R8 clear", err_o, 1'b0);

    // R9 malformed header (last on header beat)
    m0 = match_cnt;
    send(ID_A, 0, 32'h0, 1'b0, 1'b0);
    idle(2);
    check(err_o == 1, "R9 malformed sets error", err_o, 1);
    check(match_cnt == m0, "R9 no match pulse", match_cnt - m0, 0);
    send(ID_A, 1, 32'h5500_0000, 1'b0, 1'b1);
    idle(4);
    check(exp_q.size() == 0, "R9 next beat is a header", exp_q.size(), 0);

    // R8 error raised in the same cycle as a clear wins
    @(negedge clk);
    up_valid = 1'b1; up_last = 1'b1; up_data = ID_B; err_clr = 1'b1;
    @(negedge clk);
    up_valid = 1'b0; up_last = 1'b0; err_clr = 1'b0;
    #3;
    check(err_o == 1, "R8 set outranks clear", err_o, 1);

    // R5 R7 identifier change: old tag rejected, new tag accepted
    bp_en = 1'b0;
    static_id = ID_B;
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    send(ID_A, 3, 32'h6600_0000, 1'b0, 1'b0);
    idle(2);
    check(err_o == 1, "R7 stale tag rejected", err_o, 1);
    m0 = match_cnt;
    send(ID_B, 3, 32'h7700_0000, 1'b0, 1'b1);
    idle(4);
    check(match_cnt - m0 == 1, "R5 new tag accepted", match_cnt - m0, 1);
    check(exp_q.size() == 0, "R2 new tag payload", exp_q.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule